// File: doc/BRIEF.md
# Timekeeper Register Bank with Protected Burst Commit

This block is the storage behind a serial real-time-clock front end. It holds seven calendar registers, a control register that carries a global write-protect flag, a charger configuration register and a 31-byte scratch RAM. The front end passes in each command byte and each received data byte. It reads outgoing bytes from `rd_data_o`, pulsing `rd_next_i` to step through a burst.

Every write is gated by the protect flag, and the protect flag can always be cleared. A burst write to clock space is staged in a shadow buffer. It reaches the calendar only when the eighth byte, the control byte, arrives, so an interrupted burst leaves the calendar untouched. A burst write to RAM commits each byte as soon as it lands. The charger configuration is decoded into an enable, a diode count and a resistor choice. Charging is enabled only by an exact key in the upper nibble together with legal diode and resistor codes.

Top module: `rtc_regbank`

## Requirements
- R1: The command byte is {bit7 write-enable, bit6 space (0 clock, 1 RAM), bits5:1 address, bit0 read}. Address 31 selects burst mode. A write command with bit7 = 0 changes nothing.
- R2: After reset, all calendar registers, RAM bytes, the control register and the charger register read 0x00, and charging is disabled.
- R3: The control register is at clock address 7. Its bit 7 is the protect flag, and bits 6:0 always read zero.
- R4: While protect is set, writes to calendar registers (addresses 0 to 6), the charger register (address 8) and RAM are ignored. A write to the control register always takes effect.
- R5: In a single-byte write, only the first data byte after the command is stored, and later bytes are ignored.
- R6: A clock burst write (bytes for addresses 0 to 7 in order) updates the calendar and control together, and only when the eighth byte is received.
- R7: If a clock burst write ends before its eighth byte, nothing from it is stored.
- R8: If protect is set when a clock burst write command is received, the whole burst is dropped, including the control byte.
- R9: A RAM burst write stores each received byte at addresses 0, 1, 2 and so on, even when fewer than 31 bytes are sent.
- R10: Clock addresses 9 to 30 hold nothing and read 0x00. The charger register (address 8) is reachable only by single-byte access.
- R11: The charger register is {bits7:4 key, bits3:2 diode, bits1:0 resistor}. Charging is enabled only when key = 1010, diode is 01 (one diode) or 10 (two diodes), and resistor is not 00. When enabled, `chg_diodes_o` is 1 or 2 and `chg_res_o` is the resistor code. When disabled, both are 0.
- R12: A burst read presents address 0 first. Each `rd_next_i` pulse moves to the next address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| xfer_i | input | 1 | High for the whole serial transfer; low ends it |
| cmd_valid_i | input | 1 | One-cycle strobe: a command byte is on cmd_i |
| cmd_i | input | 8 | Command byte |
| wr_valid_i | input | 1 | One-cycle strobe: a data byte is on wr_data_i |
| wr_data_i | input | 8 | Received data byte |
| rd_next_i | input | 1 | Step to the next burst read byte |
| rd_data_o | output | 8 | Byte at the current read position |
| chg_en_o | output | 1 | Charger enabled |
| chg_diodes_o | output | 2 | Number of series diodes (0 when disabled) |
| chg_res_o | output | 2 | Resistor code (0 when disabled) |

## Verification
The bench checks that a clock burst cut off after five bytes leaves the calendar unchanged. A design that wrote bytes through directly would show the partial values. It starts a clock burst while protect is set and checks that the protect flag survives. A design that let the final control byte through would clear it. A RAM burst of three bytes must land in bytes 0 to 2 while byte 3 keeps its old value. This catches designs that buffer RAM bursts or write one address off. The bench also checks charger codes one step away from the key, illegal diode and resistor codes, surplus bytes after a single write, and commands with the write-enable bit clear.

// File: rtl/rtc_regbank_pkg.sv
package rtc_regbank_pkg;
  localparam int DW        = 8;
  localparam int AW        = 5;
  localparam int CAL_REGS  = 7;
  localparam int CTRL_ADDR = 7;
  localparam int TRK_ADDR  = 8;
  localparam int CLK_BURST = CAL_REGS + 1;
  localparam logic [AW-1:0] BURST_ADDR = '1;
  localparam logic [3:0] CHG_KEY = 4'b1010;

  typedef enum logic [2:0] {
    ACT_NONE,
    ACT_CLK,
    ACT_RAM,
    ACT_STAGE,
    ACT_COMMIT
  } act_e;
endpackage

// File: rtl/rtc_cmd_ctrl.sv
module rtc_cmd_ctrl
  import rtc_regbank_pkg::*;
#(
  parameter int RAM_DEPTH = 31
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          xfer_i,
  input  logic          cmd_valid_i,
  input  logic [DW-1:0] cmd_i,
  input  logic          wr_valid_i,
  input  logic          rd_next_i,
  input  logic          wp_i,
  output act_e          act_o,
  output logic [AW-1:0] idx_o,
  output logic          rd_ram_o,
  output logic          open_o
);
  localparam logic [AW-1:0] CLK_LAST = AW'(CLK_BURST - 1);
  localparam logic [AW-1:0] RAM_LAST = AW'(RAM_DEPTH - 1);

  logic          open_q, ram_q, rd_q, burst_q, wen_q, wp_lat_q, done_q;
  logic [AW-1:0] ptr_q;
  logic [AW-1:0] last;
  logic          wr_ok;

  assign last  = ram_q ? RAM_LAST : CLK_LAST;
  assign wr_ok = open_q && xfer_i && wr_valid_i && !rd_q && wen_q && !done_q;

  always_comb begin
    act_o = ACT_NONE;
    if (wr_ok) begin
      if (!burst_q)             act_o = ram_q ? ACT_RAM : ACT_CLK;
      else if (ram_q)           act_o = ACT_RAM;
      else if (ptr_q == CLK_LAST) act_o = wp_lat_q ? ACT_NONE : ACT_COMMIT;
      else                      act_o = wp_lat_q ? ACT_NONE : ACT_STAGE;
    end
  end

  assign idx_o    = ptr_q;
  assign rd_ram_o = ram_q;
  assign open_o   = open_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      open_q   <= 1'b0;
      ram_q    <= 1'b0;
      rd_q     <= 1'b0;
      burst_q  <= 1'b0;
      wen_q    <= 1'b0;
      wp_lat_q <= 1'b0;
      done_q   <= 1'b0;
      ptr_q    <= '0;
    end else if (!xfer_i) begin
      open_q <= 1'b0;
      done_q <= 1'b0;
      ptr_q  <= '0;
    end else if (cmd_valid_i) begin
      open_q   <= 1'b1;
      wen_q    <= cmd_i[7];
      ram_q    <= cmd_i[6];
      rd_q     <= cmd_i[0];
      burst_q  <= (cmd_i[5:1] == BURST_ADDR);
      ptr_q    <= (cmd_i[5:1] == BURST_ADDR) ? '0 : cmd_i[5:1];
      wp_lat_q <= wp_i;
      done_q   <= 1'b0;
    end else if (wr_ok) begin
      if (!burst_q) done_q <= 1'b1;
      else begin
        if (ptr_q == last) done_q <= 1'b1;
        else ptr_q <= ptr_q + 1'b1;
      end
    end else if (open_q && rd_q && burst_q && rd_next_i) begin
      ptr_q <= (ptr_q == last) ? '0 : ptr_q + 1'b1;
    end
  end
endmodule

// File: rtl/rtc_store.sv
module rtc_store
  import rtc_regbank_pkg::*;
#(
  parameter int RAM_DEPTH = 31
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  act_e                          act_i,
  input  logic [AW-1:0]                 idx_i,
  input  logic [DW-1:0]                 wr_data_i,
  input  logic                          rd_ram_i,
  output logic [DW-1:0]                 rd_data_o,
  output logic                          wp_o,
  output logic [DW-1:0]                 trk_o,
  output logic [CAL_REGS-1:0][DW-1:0]   cal_o,
  output logic [RAM_DEPTH-1:0][DW-1:0]  ram_o
);
  logic [CAL_REGS-1:0][DW-1:0]  cal_q, stage_q;
  logic [RAM_DEPTH-1:0][DW-1:0] ram_q;
  logic                         wp_q;
  logic [DW-1:0]                trk_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cal_q   <= '0;
      stage_q <= '0;
      wp_q    <= 1'b0;
      trk_q   <= '0;
    end else begin
      unique case (act_i)
        ACT_CLK: begin
          if (idx_i == AW'(CTRL_ADDR)) wp_q <= wr_data_i[7];
          else if (!wp_q) begin
            if (idx_i < AW'(CAL_REGS))      cal_q[idx_i[2:0]] <= wr_data_i;
            else if (idx_i == AW'(TRK_ADDR)) trk_q <= wr_data_i;
          end
        end
        ACT_STAGE: if (idx_i < AW'(CAL_REGS)) stage_q[idx_i[2:0]] <= wr_data_i;
        ACT_COMMIT: begin
          cal_q <= stage_q;
          wp_q  <= wr_data_i[7];
        end
        default: ;
      endcase
    end
  end

  // per-byte enables; RAM burst and single writes share the same path
  for (genvar g = 0; g < RAM_DEPTH; g++) begin : g_ram
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) ram_q[g] <= '0;
      else if (act_i == ACT_RAM && !wp_q && idx_i == AW'(g)) ram_q[g] <= wr_data_i;
    end
  end

  always_comb begin
    rd_data_o = '0;
    if (rd_ram_i) begin
      if (idx_i < AW'(RAM_DEPTH)) rd_data_o = ram_q[idx_i];
    end else if (idx_i < AW'(CAL_REGS)) rd_data_o = cal_q[idx_i[2:0]];
    else if (idx_i == AW'(CTRL_ADDR))   rd_data_o = {wp_q, 7'b0};
    else if (idx_i == AW'(TRK_ADDR))    rd_data_o = trk_q;
  end

  assign wp_o  = wp_q;
  assign trk_o = trk_q;
  assign cal_o = cal_q;
  assign ram_o = ram_q;
endmodule

// File: rtl/rtc_chg_decode.sv
module rtc_chg_decode
  import rtc_regbank_pkg::*;
(
  input  logic [DW-1:0] cfg_i,
  output logic          en_o,
  output logic [1:0]    diodes_o,
  output logic [1:0]    res_o
);
  logic key_ok, diode_ok, res_ok;
  assign key_ok   = (cfg_i[7:4] == CHG_KEY);
  assign diode_ok = (cfg_i[3:2] == 2'b01) || (cfg_i[3:2] == 2'b10);
  assign res_ok   = (cfg_i[1:0] != 2'b00);
  assign en_o     = key_ok && diode_ok && res_ok;
  assign diodes_o = en_o ? ((cfg_i[3:2] == 2'b01) ? 2'd1 : 2'd2) : 2'd0;
  assign res_o    = en_o ? cfg_i[1:0] : 2'b00;
endmodule

// File: rtl/rtc_regbank.sv
module rtc_regbank
  import rtc_regbank_pkg::*;
#(
  parameter int RAM_DEPTH = 31
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          xfer_i,
  input  logic          cmd_valid_i,
  input  logic [7:0]    cmd_i,
  input  logic          wr_valid_i,
  input  logic [7:0]    wr_data_i,
  input  logic          rd_next_i,
  output logic [7:0]    rd_data_o,
  output logic          chg_en_o,
  output logic [1:0]    chg_diodes_o,
  output logic [1:0]    chg_res_o
);
  act_e                         act;
  logic [AW-1:0]                idx;
  logic                         rd_ram, open_s, wp;
  logic [DW-1:0]                trk;
  logic [CAL_REGS-1:0][DW-1:0]  cal;
  logic [RAM_DEPTH-1:0][DW-1:0] ram;

  rtc_cmd_ctrl #(.RAM_DEPTH(RAM_DEPTH)) u_ctrl (
    .clk_i, .rst_ni, .xfer_i, .cmd_valid_i, .cmd_i, .wr_valid_i, .rd_next_i,
    .wp_i(wp), .act_o(act), .idx_o(idx), .rd_ram_o(rd_ram), .open_o(open_s)
  );

  rtc_store #(.RAM_DEPTH(RAM_DEPTH)) u_store (
    .clk_i, .rst_ni, .act_i(act), .idx_i(idx), .wr_data_i, .rd_ram_i(rd_ram),
    .rd_data_o, .wp_o(wp), .trk_o(trk), .cal_o(cal), .ram_o(ram)
  );

  rtc_chg_decode u_chg (
    .cfg_i(trk), .en_o(chg_en_o), .diodes_o(chg_diodes_o), .res_o(chg_res_o)
  );
endmodule

// File: rtl/rtc_regbank_chk.sv
module rtc_regbank_chk
  import rtc_regbank_pkg::*;
#(
  parameter int RAM_DEPTH = 31
) (
  input logic                         clk_i,
  input logic                         rst_ni,
  input logic                         xfer_i,
  input act_e                         act,
  input logic [AW-1:0]                idx,
  input logic                         rd_ram,
  input logic                         open_s,
  input logic                         wp,
  input logic [DW-1:0]                trk,
  input logic [CAL_REGS-1:0][DW-1:0]  cal,
  input logic [RAM_DEPTH-1:0][DW-1:0] ram,
  input logic [7:0]                   rd_data_o,
  input logic                         chg_en_o,
  input logic [1:0]                   chg_diodes_o,
  input logic [1:0]                   chg_res_o
);
  // R4
  wp_blocks_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wp |=> ($stable(cal) && $stable(ram) && $stable(trk)));
  // R3
  ctrl_low_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!rd_ram && idx == AW'(CTRL_ADDR)) |-> (rd_data_o[6:0] == 7'b0));
  // R6
  cal_commit_only_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (act != ACT_CLK && act != ACT_COMMIT) |=> $stable(cal));
  // R7
  xfer_end_closes_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !xfer_i |=> !open_s);
  // R11
  chg_legal_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    chg_en_o |-> (chg_res_o != 2'b00 && (chg_diodes_o == 2'd1 || chg_diodes_o == 2'd2)));
  // R11
  chg_off_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !chg_en_o |-> (chg_res_o == 2'b00 && chg_diodes_o == 2'd0));
endmodule

bind rtc_regbank rtc_regbank_chk #(.RAM_DEPTH(RAM_DEPTH)) u_chk (
  .clk_i, .rst_ni, .xfer_i, .act, .idx, .rd_ram, .open_s, .wp, .trk, .cal, .ram,
  .rd_data_o, .chg_en_o, .chg_diodes_o, .chg_res_o
);

// File: tb/rtc_regbank_test.sv
module rtc_regbank_test;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 8;
  // {ram, addr[4:0], wdata, expected}
  localparam logic [21:0] VEC [NVEC] = '{
    {1'b0, 5'd0,  8'h59, 8'h59},
    {1'b0, 5'd2,  8'h23, 8'h23},
    {1'b0, 5'd6,  8'h99, 8'h99},
    {1'b0, 5'd7,  8'h7F, 8'h00},
    {1'b0, 5'd8,  8'hA5, 8'hA5},
    {1'b0, 5'd12, 8'h33, 8'h00},
    {1'b1, 5'd0,  8'hC3, 8'hC3},
    {1'b1, 5'd30, 8'h5A, 8'h5A}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic xfer = 0, cmd_v = 0, wr_v = 0, rd_next = 0;
  logic [7:0] cmd = '0, wd = '0;
  logic [7:0] rd_data;
  logic chg_en;
  logic [1:0] chg_diodes, chg_res;
  int n_run = 0, n_fail = 0;
  logic [7:0] d;

  always #(CLK_PERIOD/2) clk = ~clk;

  rtc_regbank uut (
    .clk_i(clk), .rst_ni(rst_n), .xfer_i(xfer), .cmd_valid_i(cmd_v), .cmd_i(cmd),
    .wr_valid_i(wr_v), .wr_data_i(wd), .rd_next_i(rd_next), .rd_data_o(rd_data),
    .chg_en_o(chg_en), .chg_diodes_o(chg_diodes), .chg_res_o(chg_res)
  );

  function automatic logic [7:0] mk(input logic ram, input logic [4:0] a, input logic rd);
    return {1'b1, ram, a, rd};
  endfunction

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic open_cmd(input logic [7:0] c);
    @(negedge clk); xfer = 1; cmd = c; cmd_v = 1;
    @(negedge clk); cmd_v = 0;
  endtask
  task automatic wr(input logic [7:0] v);
    wr_v = 1; wd = v; @(negedge clk); wr_v = 0;
  endtask
  task automatic close_x();
    xfer = 0; @(negedge clk);
  endtask
  task automatic wr1(input logic ram, input logic [4:0] a, input logic [7:0] v);
    open_cmd(mk(ram, a, 1'b0)); wr(v); close_x();
  endtask
  task automatic rd1(input logic ram, input logic [4:0] a, output logic [7:0] v);
    open_cmd(mk(ram, a, 1'b1)); v = rd_data; close_x();
  endtask
  task automatic chk_chg(input string req, input logic e, input logic [1:0] nd, input logic [1:0] r);
    chk(req, {5'b0, chg_en, chg_res}, {5'b0, e, r});
    chk(req, {6'b0, chg_diodes}, {6'b0, nd});
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    n_run++; n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R2 reset state
    rd1(1'b0, 5'd0, d); chk("R2 sec", d, 8'h00);
    rd1(1'b0, 5'd7, d); chk("R2 ctrl", d, 8'h00);
    rd1(1'b0, 5'd8, d); chk("R2 trk", d, 8'h00);
    rd1(1'b1, 5'd4, d); chk("R2 ram", d, 8'h00);
    chk_chg("R2 chg", 1'b0, 2'd0, 2'd0);

    // table walk: R3 R10 single write then read back
    for (int i = 0; i < NVEC; i++) begin
      wr1(VEC[i][21], VEC[i][20:16], VEC[i][15:8]);
      rd1(VEC[i][21], VEC[i][20:16], d);
      chk("R3/R10 vec", d, VEC[i][7:0]);
    end
    // R11 A5 -> one diode, resistor 1
    chk_chg("R11 A5", 1'b1, 2'd1, 2'd1);
    wr1(1'b0, 5'd8, 8'hAA); chk_chg("R11 AA", 1'b1, 2'd2, 2'd2);
    wr1(1'b0, 5'd8, 8'hA7); chk_chg("R11 A7", 1'b1, 2'd1, 2'd3);
    wr1(1'b0, 5'd8, 8'hAD); chk_chg("R11 ds11", 1'b0, 2'd0, 2'd0);
    wr1(1'b0, 5'd8, 8'hA4); chk_chg("R11 rs00", 1'b0, 2'd0, 2'd0);
    wr1(1'b0, 5'd8, 8'hB5); chk_chg("R11 key", 1'b0, 2'd0, 2'd0);
    wr1(1'b0, 5'd8, 8'hA5);

    // R5 surplus bytes
    open_cmd(mk(1'b1, 5'd5, 1'b0)); wr(8'h11); wr(8'h22); close_x();
    rd1(1'b1, 5'd5, d); chk("R5", d, 8'h11);
    // R1 write-enable bit clear
    open_cmd(8'h4A); wr(8'h99); close_x();
    rd1(1'b1, 5'd5, d); chk("R1", d, 8'h11);

    // R4 protect
    wr1(1'b0, 5'd7, 8'h80);
    rd1(1'b0, 5'd7, d); chk("R3 wp set", d, 8'h80);
    wr1(1'b1, 5'd5, 8'h44); rd1(1'b1, 5'd5, d); chk("R4 ram", d, 8'h11);
    wr1(1'b0, 5'd0, 8'h01); rd1(1'b0, 5'd0, d); chk("R4 cal", d, 8'h59);
    wr1(1'b0, 5'd8, 8'h00); chk_chg("R4 trk", 1'b1, 2'd1, 2'd1);
    // R8 burst under protect, ctrl byte clears wp but must be dropped
    open_cmd(mk(1'b0, 5'd31, 1'b0));
    for (int i = 0; i < 8; i++) wr(8'h00);
    close_x();
    rd1(1'b0, 5'd7, d); chk("R8 ctrl", d, 8'h80);
    rd1(1'b0, 5'd0, d); chk("R8 sec", d, 8'h59);
    wr1(1'b0, 5'd7, 8'h00);
    rd1(1'b0, 5'd7, d); chk("R4 clear", d, 8'h00);

    // R6 full clock burst
    open_cmd(mk(1'b0, 5'd31, 1'b0));
    for (int i = 0; i < 7; i++) wr(8'h10 + 8'(i));
    rd1(1'b0, 5'd0, d); // transfer closed by rd1: burst aborted at 7 -> R7
    chk("R7 seven bytes", d, 8'h59);
    open_cmd(mk(1'b0, 5'd31, 1'b0));
    for (int i = 0; i < 7; i++) wr(8'h10 + 8'(i));
    wr(8'h00); close_x();
    for (int i = 0; i < 7; i++) begin
      rd1(1'b0, 5'(i), d); chk("R6", d, 8'h10 + 8'(i));
    end
    // R12 burst read
    open_cmd(mk(1'b0, 5'd31, 1'b1));
    for (int i = 0; i < 8; i++) begin
      chk("R12", rd_data, (i == 7) ? 8'h00 : 8'h10 + 8'(i));
      rd_next = 1; @(negedge clk); rd_next = 0;
    end
    close_x();
    // R7 aborted after five
    open_cmd(mk(1'b0, 5'd31, 1'b0));
    for (int i = 0; i < 5; i++) wr(8'h20 + 8'(i));
    close_x();
    rd1(1'b0, 5'd0, d); chk("R7", d, 8'h10);
    rd1(1'b0, 5'd4, d); chk("R7", d, 8'h14);
    // R9 partial RAM burst
    open_cmd(mk(1'b1, 5'd31, 1'b0));
    wr(8'hA0); wr(8'hA1); wr(8'hA2); close_x();
    rd1(1'b1, 5'd0, d); chk("R9 b0", d, 8'hA0);
    rd1(1'b1, 5'd2, d); chk("R9 b2", d, 8'hA2);
    rd1(1'b1, 5'd3, d); chk("R9 b3", d, 8'h00);
    // R10 trickle unreachable by burst: clock burst read of 8 never shows it
    rd1(1'b0, 5'd20, d); chk("R10 empty", d, 8'h00);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule